// File: doc/BRIEF.md
# Direct-Mapped Translation and Permission Lookup Unit

This block translates a virtual address into a physical address for a small RISC core and decides whether the requested access is allowed. It keeps two direct-mapped tables, one for instruction pages and one for data pages. Each slot holds a tag word, whose bit 0 is a valid flag, and a translation word that carries the physical page and the permission bits. One index taken from the virtual page number selects a slot in both tables at once. The block merges the two slots into one execute/write/read vector and checks the needed right against that vector. When the access fails, it reports whether a valid entry existed that lacked the right (a page fault) or no usable entry existed (a miss).

Software or a refill engine loads the slots through a write port. The core presents a request strobe with the address, the access kind and the privilege level, and gets the result one cycle later. On any failure the block latches the faulting address and sets the reservation-lock address to all ones. When translation is switched off, addresses pass through unchanged with every right granted.

Top module: `xlat_perm_unit`

## Requirements
- R1: After reset, `rsp_valid` is 0, `rsp_code` is 0, and `rsp_pa`, `rsp_perm`, `fault_addr` and `lock_addr` are all zero.
- R2: `rsp_valid` is 1 in exactly the cycle after a cycle with `req_valid` high. The response fields change only after a request.
- R3: With `mmu_on` low, the response has `rsp_pa` equal to `req_va`, `rsp_perm` = 3'b111 and `rsp_code` = 0, whatever the tables hold.
- R4: The slot index is `req_va[18:13]`. A slot hits when bits [31:13] of its tag word equal bits [31:13] of `req_va`. `rsp_pa` is the OR of bits [31:13] of both translation words, followed by `req_va[12:0]`.
- R5: `rsp_perm` is {exec, write, read}. Exec comes from bit 6 (user) or bit 7 (supervisor) of the instruction translation word. Read comes from bit 6 (user) or bit 8 (supervisor) of the data translation word. Write comes from bit 7 (user) or bit 9 (supervisor) of the data translation word. `req_super` selects the user or supervisor bit.
- R6: If bits [31:13] of the two translation words differ, a fetch (`req_acc` = 0) ignores the data slot, and any other access ignores the instruction slot.
- R7: The needed right is exec for a fetch (0), write for a store (2), and read for a load (1) or code 3. `rsp_code` is 0 for success, 1 for an instruction page fault, 2 for a data page fault, 3 for an instruction miss and 4 for a data miss.
- R8: On a failing response, `fault_addr` holds the request's address and `lock_addr` is all ones. A successful response leaves both unchanged.
- R9: A write with `wr_tbl` (0 = instruction, 1 = data), `wr_word` (0 = tag, 1 = translation), `wr_idx` and `wr_data` replaces exactly that word and is visible to requests from the next cycle.
- R10: A slot whose tag bit 0 is 0 grants no right and counts as absent. A failure on it is a miss, not a page fault.
- R11: `rsp_perm` is reported on failures too, and contains only rights from valid, hitting slots.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Table write strobe |
| wr_tbl | input | 1 | 0 = instruction table, 1 = data table |
| wr_word | input | 1 | 0 = tag word, 1 = translation word |
| wr_idx | input | 6 | Slot index for the write |
| wr_data | input | 32 | Word to write |
| req_valid | input | 1 | Lookup request strobe |
| req_va | input | 32 | Virtual address |
| req_acc | input | 2 | 0 fetch, 1 load, 2 store, 3 treated as load |
| req_super | input | 1 | Supervisor privilege |
| mmu_on | input | 1 | Translation enable; low selects pass-through |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_pa | output | 32 | Physical address |
| rsp_perm | output | 3 | {exec, write, read} rights |
| rsp_code | output | 3 | Result code |
| fault_addr | output | 32 | Address of the last failing request |
| lock_addr | output | 32 | Reservation-lock address, all ones after a failure |

## Verification
The properties assume that `req_va`, `req_acc`, `req_super` and `mmu_on` are driven to known values whenever `req_valid` is high, and that reset is held for at least two clock edges. They also assume that the write port and the request side change only away from the sampling edge. The stimulus drives every input on the falling edge and keeps reset high for several cycles. It loads every slot of both tables before the first translated request, so no lookup reads an uninitialised word. Random traffic is limited to four slots and a small set of tags, so hits, misses, faults and writes that overlap lookups all occur often.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
  // access kinds presented with a request
  localparam logic [1:0] ACC_FETCH = 2'd0;
  localparam logic [1:0] ACC_LOAD  = 2'd1;
  localparam logic [1:0] ACC_STORE = 2'd2;

  // result codes
  typedef enum logic [2:0] {
    RC_OK    = 3'd0,
    RC_IPF   = 3'd1,
    RC_DPF   = 3'd2,
    RC_IMISS = 3'd3,
    RC_DMISS = 3'd4
  } rcode_e;

  // permission vector positions
  localparam int P_RD = 0;
  localparam int P_WR = 1;
  localparam int P_EX = 2;

  // permission bits inside translation words
  localparam int XB_USR = 6;
  localparam int XB_SUP = 7;
  localparam int RB_USR = 6;
  localparam int WB_USR = 7;
  localparam int RB_SUP = 8;
  localparam int WB_SUP = 9;
endpackage

// File: rtl/xlat_table.sv
module xlat_table #(
  parameter int AW    = 32,
  parameter int DEPTH = 64,
  localparam int IW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic          wsel,
  input  logic [IW-1:0] widx,
  input  logic [AW-1:0] wdata,
  input  logic [IW-1:0] ridx,
  output logic [AW-1:0] rtag,
  output logic [AW-1:0] rxl
);
  logic [AW-1:0] tag_mem [DEPTH];
  logic [AW-1:0] xl_mem  [DEPTH];

  always_ff @(posedge clk) begin
    if (we && !wsel) tag_mem[widx] <= wdata;
    if (we &&  wsel) xl_mem[widx]  <= wdata;
  end

  assign rtag = tag_mem[ridx];
  assign rxl  = xl_mem[ridx];
endmodule

// File: rtl/xlat_check.sv
module xlat_check import xlat_pkg::*; #(
  parameter int AW    = 32,
  parameter int OFS_W = 13
) (
  input  logic [AW-1:0] va,
  input  logic [1:0]    acc,
  input  logic          sup,
  input  logic [AW-1:0] itag_in,
  input  logic [AW-1:0] ixl_in,
  input  logic [AW-1:0] dtag_in,
  input  logic [AW-1:0] dxl_in,
  output logic [AW-1:0] pa,
  output logic [2:0]    perm,
  output rcode_e        code
);
  localparam int PN_W = AW - OFS_W;

  logic [AW-1:0] itag, ixl, dtag, dxl;
  logic          is_fetch;
  logic [2:0]    hit, vld, rights, need;
  logic          unused_bits;

  assign is_fetch = (acc == ACC_FETCH);

  always_comb begin
    itag = itag_in; ixl = ixl_in; dtag = dtag_in; dxl = dxl_in;
    if (ixl_in[AW-1:OFS_W] != dxl_in[AW-1:OFS_W]) begin
      if (is_fetch) begin
        dtag = '0; dxl = '0;
      end else begin
        itag = '0; ixl = '0;
      end
    end
  end

  always_comb begin
    hit         = '0;
    hit[P_EX]   = (itag[AW-1:OFS_W] == va[AW-1:OFS_W]);
    hit[P_RD]   = (dtag[AW-1:OFS_W] == va[AW-1:OFS_W]);
    hit[P_WR]   = hit[P_RD];
    vld         = {itag[0], dtag[0], dtag[0]} & hit;
    rights[P_EX] = sup ? ixl[XB_SUP] : ixl[XB_USR];
    rights[P_RD] = sup ? dxl[RB_SUP] : dxl[RB_USR];
    rights[P_WR] = sup ? dxl[WB_SUP] : dxl[WB_USR];
    rights       = rights & vld;
  end

  always_comb begin
    need = '0;
    if (is_fetch)              need[P_EX] = 1'b1;
    else if (acc == ACC_STORE) need[P_WR] = 1'b1;
    else                       need[P_RD] = 1'b1;
  end

  always_comb begin
    if (|(need & rights))   code = RC_OK;
    else if (|(need & vld)) code = is_fetch ? RC_IPF : RC_DPF;
    else                    code = is_fetch ? RC_IMISS : RC_DMISS;
  end

  assign perm = rights;
  assign pa   = {PN_W'(ixl[AW-1:OFS_W] | dxl[AW-1:OFS_W]), va[OFS_W-1:0]};
  assign unused_bits = ^{itag[OFS_W-1:1], dtag[OFS_W-1:1], ixl[OFS_W-1:0], dxl[OFS_W-1:0]};
endmodule

// File: rtl/xlat_perm_unit.sv
module xlat_perm_unit import xlat_pkg::*; #(
  parameter int AW      = 32,
  parameter int OFS_W   = 13,
  parameter int ENTRIES = 64,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic             wr_tbl,
  input  logic             wr_word,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [AW-1:0]    wr_data,
  input  logic             req_valid,
  input  logic [AW-1:0]    req_va,
  input  logic [1:0]       req_acc,
  input  logic             req_super,
  input  logic             mmu_on,
  output logic             rsp_valid,
  output logic [AW-1:0]    rsp_pa,
  output logic [2:0]       rsp_perm,
  output logic [2:0]       rsp_code,
  output logic [AW-1:0]    fault_addr,
  output logic [AW-1:0]    lock_addr
);
  logic [IDX_W-1:0] look_idx;
  logic [AW-1:0]    rd_tag [2];
  logic [AW-1:0]    rd_xl  [2];
  logic [AW-1:0]    chk_pa;
  logic [2:0]       chk_perm;
  rcode_e           chk_code;
  logic [AW-1:0]    nxt_pa;
  logic [2:0]       nxt_perm;
  rcode_e           nxt_code;

  assign look_idx = req_va[OFS_W +: IDX_W];

  // index 0 = instruction table, 1 = data table
  for (genvar t = 0; t < 2; t++) begin : g_tbl
    xlat_table #(.AW(AW), .DEPTH(ENTRIES)) u_tbl (
      .clk   (clk),
      .we    (wr_en && (wr_tbl == 1'(t))),
      .wsel  (wr_word),
      .widx  (wr_idx),
      .wdata (wr_data),
      .ridx  (look_idx),
      .rtag  (rd_tag[t]),
      .rxl   (rd_xl[t])
    );
  end

  xlat_check #(.AW(AW), .OFS_W(OFS_W)) u_chk_logic (
    .va      (req_va),
    .acc     (req_acc),
    .sup     (req_super),
    .itag_in (rd_tag[0]),
    .ixl_in  (rd_xl[0]),
    .dtag_in (rd_tag[1]),
    .dxl_in  (rd_xl[1]),
    .pa      (chk_pa),
    .perm    (chk_perm),
    .code    (chk_code)
  );

  always_comb begin
    if (mmu_on) begin
      nxt_pa = chk_pa; nxt_perm = chk_perm; nxt_code = chk_code;
    end else begin
      nxt_pa = req_va; nxt_perm = 3'b111; nxt_code = RC_OK;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid  <= 1'b0;
      rsp_pa     <= '0;
      rsp_perm   <= '0;
      rsp_code   <= RC_OK;
      fault_addr <= '0;
      lock_addr  <= '0;
    end else begin
      rsp_valid <= req_valid;
      if (req_valid) begin
        rsp_pa   <= nxt_pa;
        rsp_perm <= nxt_perm;
        rsp_code <= nxt_code;
        if (nxt_code != RC_OK) begin
          fault_addr <= req_va;
          lock_addr  <= '1;
        end
      end
    end
  end
endmodule

// File: rtl/xlat_perm_unit_chk.sv
module xlat_perm_unit_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          req_valid,
  input logic [AW-1:0] req_va,
  input logic          mmu_on,
  input logic          rsp_valid,
  input logic [AW-1:0] rsp_pa,
  input logic [2:0]    rsp_perm,
  input logic [2:0]    rsp_code,
  input logic [AW-1:0] fault_addr,
  input logic [AW-1:0] lock_addr
);
  // R2
  a_r2_rsp_follows_req: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid);
  a_r2_no_rsp_without_req: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !rsp_valid);

  // R3
  a_r3_bypass_passthru: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !mmu_on) |=>
      (rsp_pa == $past(req_va) && rsp_perm == 3'b111 && rsp_code == 3'd0));

  // R7
  a_r7_code_range: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> (rsp_code <= 3'd4));
  a_r7_success_has_right: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_code == 3'd0) |-> (rsp_perm != 3'b000));

  // R8
  a_r8_fault_capture: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_code != 3'd0) |->
      (fault_addr == $past(req_va) && lock_addr == {AW{1'b1}}));
  a_r8_hold_on_success: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && (!rsp_valid || rsp_code == 3'd0)) |->
      ($stable(fault_addr) && $stable(lock_addr)));
endmodule

bind xlat_perm_unit xlat_perm_unit_chk #(.AW(AW)) u_prop_chk (
  .clk        (clk),
  .rst        (rst),
  .req_valid  (req_valid),
  .req_va     (req_va),
  .mmu_on     (mmu_on),
  .rsp_valid  (rsp_valid),
  .rsp_pa     (rsp_pa),
  .rsp_perm   (rsp_perm),
  .rsp_code   (rsp_code),
  .fault_addr (fault_addr),
  .lock_addr  (lock_addr)
);

// File: tb/xlat_perm_unit_tb_top.sv
module xlat_perm_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0, wr_tbl = 1'b0, wr_word = 1'b0;
  logic [5:0]  wr_idx = '0;
  logic [31:0] wr_data = '0;
  logic        req_valid = 1'b0;
  logic [31:0] req_va = '0;
  logic [1:0]  req_acc = '0;
  logic        req_super = 1'b0, mmu_on = 1'b0;
  logic        rsp_valid;
  logic [31:0] rsp_pa, fault_addr, lock_addr;
  logic [2:0]  rsp_perm, rsp_code;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  xlat_perm_unit dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_tbl(wr_tbl), .wr_word(wr_word),
    .wr_idx(wr_idx), .wr_data(wr_data), .req_valid(req_valid), .req_va(req_va),
    .req_acc(req_acc), .req_super(req_super), .mmu_on(mmu_on),
    .rsp_valid(rsp_valid), .rsp_pa(rsp_pa), .rsp_perm(rsp_perm),
    .rsp_code(rsp_code), .fault_addr(fault_addr), .lock_addr(lock_addr)
  );

  // reference tables: [0] instruction, [1] data
  logic [31:0] m_tag [2][64];
  logic [31:0] m_xl  [2][64];
  logic        e_valid;
  logic [31:0] e_pa, e_fault, e_lock;
  logic [2:0]  e_perm, e_code;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic void ref_lookup(input logic [31:0] va, input logic [1:0] acc,
      input logic sup, input logic on, output logic [31:0] pa,
      output logic [2:0] perm, output logic [2:0] code);
    int i;
    logic [31:0] it, ix, dt, dx;
    bit fetch, vx, vd, rx, rr, rw, want_x, want_w, want_r, granted, present;
    if (!on) begin
      pa = va; perm = 3'b111; code = 3'd0;
      return;
    end
    i = int'(va[18:13]);
    it = m_tag[0][i]; ix = m_xl[0][i]; dt = m_tag[1][i]; dx = m_xl[1][i];
    fetch = (acc == 2'd0);
    if (ix[31:13] != dx[31:13]) begin
      if (fetch) begin dt = 0; dx = 0; end
      else begin it = 0; ix = 0; end
    end
    vx = it[0] && (it[31:13] == va[31:13]);
    vd = dt[0] && (dt[31:13] == va[31:13]);
    rx = vx && (sup ? ix[7] : ix[6]);
    rr = vd && (sup ? dx[8] : dx[6]);
    rw = vd && (sup ? dx[9] : dx[7]);
    perm = {rx, rw, rr};
    pa = {ix[31:13] | dx[31:13], va[12:0]};
    want_x = fetch; want_w = (acc == 2'd2); want_r = !fetch && !want_w;
    granted = (want_x && rx) || (want_w && rw) || (want_r && rr);
    present = (want_x && vx) || ((want_w || want_r) && vd);
    if (granted)      code = 3'd0;
    else if (present) code = fetch ? 3'd1 : 3'd2;
    else              code = fetch ? 3'd3 : 3'd4;
  endfunction

  // cycle model: updated on every rising edge
  always @(posedge clk) begin
    logic [31:0] p; logic [2:0] pm, c;
    if (rst) begin
      e_valid = 0; e_pa = 0; e_perm = 0; e_code = 0; e_fault = 0; e_lock = 0;
    end else begin
      e_valid = req_valid;
      if (req_valid) begin
        ref_lookup(req_va, req_acc, req_super, mmu_on, p, pm, c);
        e_pa = p; e_perm = pm; e_code = c;
        if (c != 3'd0) begin e_fault = req_va; e_lock = 32'hFFFF_FFFF; end
      end
      if (wr_en) begin
        if (wr_word) m_xl[wr_tbl][wr_idx] = wr_data;
        else         m_tag[wr_tbl][wr_idx] = wr_data;
      end
    end
  end

  // compare on every falling edge
  always @(negedge clk) begin
    if (!rst && !done) begin
      check("R2 rsp_valid", 32'(rsp_valid), 32'(e_valid));
      check(mmu_on ? "R4 rsp_pa" : "R3 rsp_pa", rsp_pa, e_pa);
      check("R5 rsp_perm", 32'(rsp_perm), 32'(e_perm));
      check("R7 rsp_code", 32'(rsp_code), 32'(e_code));
      check("R8 fault_addr", fault_addr, e_fault);
      check("R8 lock_addr", lock_addr, e_lock);
    end
  end

  task automatic wr(input bit tbl, input bit word, input int idx, input logic [31:0] d);
    wr_en = 1; wr_tbl = tbl; wr_word = word; wr_idx = 6'(idx); wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rq(input logic [31:0] va, input logic [1:0] acc, input bit sup, input bit on);
    req_valid = 1; req_va = va; req_acc = acc; req_super = sup; mmu_on = on;
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic finish_run();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    for (int t = 0; t < 2; t++)
      for (int i = 0; i < 64; i++) begin m_tag[t][i] = 0; m_xl[t][i] = 0; end
    repeat (4) @(negedge clk);
    rst = 0;
    // R1: reset values
    check("R1 rsp_valid", 32'(rsp_valid), 0);
    check("R1 rsp_code", 32'(rsp_code), 0);
    check("R1 fault_addr", fault_addr, 0);
    check("R1 lock_addr", lock_addr, 0);
    check("R1 rsp_pa", rsp_pa, 0);

    // R9: clear every word of both tables
    for (int t = 0; t < 2; t++)
      for (int i = 0; i < 64; i++) begin
        wr(t[0], 0, i, 32'h0);
        wr(t[0], 1, i, 32'h0);
      end

    // R3: pass-through
    rq(32'hDEAD_BEEF, 2'd2, 0, 0);
    check("R3 pa", rsp_pa, 32'hDEAD_BEEF);
    check("R3 perm", 32'(rsp_perm), 32'h7);
    check("R3 code", 32'(rsp_code), 0);

    // R10: empty slot misses
    rq(32'h0000_A123, 2'd0, 0, 1);
    check("R10 fetch miss", 32'(rsp_code), 3);
    check("R8 lock set", lock_addr, 32'hFFFF_FFFF);

    // slot 5, page 5, physical page 0x12346000, user exec + user read
    wr(0, 0, 5, 32'h0000_A001);
    wr(0, 1, 5, 32'h1234_6040);
    wr(1, 0, 5, 32'h0000_A001);
    wr(1, 1, 5, 32'h1234_6040);
    rq(32'h0000_A123, 2'd0, 0, 1);
    check("R4 fetch ok", 32'(rsp_code), 0);
    check("R4 pa", rsp_pa, 32'h1234_6123);
    check("R11 merged perm", 32'(rsp_perm), 32'b101);
    check("R8 hold on ok", fault_addr, 32'h0000_A123);
    rq(32'h0000_A123, 2'd2, 0, 1);
    check("R7 store dpf", 32'(rsp_code), 2);
    rq(32'h0000_A123, 2'd0, 1, 1);
    check("R5 super exec ipf", 32'(rsp_code), 1);
    rq(32'h0000_A123, 2'd3, 1, 1);
    check("R5 super read dpf", 32'(rsp_code), 2);
    wr(1, 1, 5, 32'h1234_6300); // supervisor read+write
    rq(32'h0000_A123, 2'd2, 1, 1);
    check("R5 super store ok", 32'(rsp_code), 0);

    // R6: different physical pages
    wr(1, 1, 5, 32'h5555_6040);
    rq(32'h0000_A123, 2'd0, 0, 1);
    check("R6 fetch pa", rsp_pa, 32'h1234_6123);
    check("R6 fetch perm", 32'(rsp_perm), 32'b100);
    rq(32'h0000_A123, 2'd1, 0, 1);
    check("R6 load pa", rsp_pa, 32'h5555_6123);
    check("R6 load perm", 32'(rsp_perm), 32'b001);

    // R10: valid bit cleared
    wr(0, 0, 5, 32'h0000_A000);
    rq(32'h0000_A123, 2'd0, 0, 1);
    check("R10 invalid miss", 32'(rsp_code), 3);

    // R4: tag mismatch on same slot
    rq(32'h0008_A123, 2'd1, 0, 1);
    check("R4 tag miss", 32'(rsp_code), 4);
    check("R8 fault addr", fault_addr, 32'h0008_A123);

    // random traffic over four slots, overlapping writes and lookups
    for (int k = 0; k < 3000; k++) begin
      logic [31:0] va;
      int idx;
      idx = int'($urandom_range(0, 3));
      va = {15'h0, 2'($urandom), 6'(idx), 13'($urandom)};
      wr_en = ($urandom_range(0, 9) < 3);
      wr_tbl = 1'($urandom); wr_word = 1'($urandom);
      wr_idx = 6'($urandom_range(0, 3));
      wr_data = wr_word ? {17'h0, 2'($urandom), 13'($urandom)}
                        : {15'h0, 2'($urandom), 2'b0, wr_idx[3:0], 12'($urandom), 1'($urandom)};
      if (wr_word && $urandom_range(0, 1) == 1) wr_data[31:13] = '0;
      req_valid = ($urandom_range(0, 9) < 7);
      req_va = va; req_acc = 2'($urandom); req_super = 1'($urandom);
      mmu_on = ($urandom_range(0, 9) != 0);
      @(negedge clk);
    end
    wr_en = 0; req_valid = 0;
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule